// File: doc/BRIEF.md
# Serial IRQ Source Router

This block decides which logical-device interrupt line drives each of sixteen host interrupt slots. Each slot has one 8-bit routing byte, and software writes that byte through a byte-wide configuration port. The byte names a source device by number and selects either the device's first or its second interrupt output. The result is a 16-bit level vector. A downstream serial-IRQ frame serializer shifts that vector out to the host.

Routing is combinational, from the stored bytes and the live source lines to the output. A change on a source therefore reaches its slot in the same cycle. A global serial-IRQ enable input gates every slot. The reset value of a routing byte, FFh, switches its slot off. Software brings up a slot by writing a device number with the device bit clear. Keyboard and mouse sit on one device, with the mouse as its second line. The mailbox, the memory-window event device and the configuration-port software interrupt are further sources.

Top module: `sirq_router`

## Requirements
- R1: After reset every routing byte reads FFh and every bit of `irq_out` is 0.
- R2: A write to configuration offset 40h+n (n = 0..15) stores the data byte as the routing byte of slot n, and a read at that offset returns it from the next cycle.
- R3: Writes to offsets outside 40h–4Fh change no routing byte and no output, and reads at those offsets return FFh.
- R4: Bits 5:0 of a routing byte are the source device number. With bit 7 (select) = 0 and bit 6 (device) = 0, the slot carries that device's first interrupt line, in the same cycle as the line changes.
- R5: With select = 1 and device = 0, the slot carries the second interrupt line of the named device. Devices 0, 1 and 9 have a second line.
- R6: A routing byte with bit 6 (device) = 1 drives its slot to 0, whatever its sources do.
- R7: The value FFh disables its slot: the output is 0 with every source high.
- R8: A slot that names a device with no first line drives 0. So does a slot that selects a second line on a device lacking one. Devices with a first line are 0, 1, 3, 4, 7, 9, 0Ah, 0Bh and 0Ch.
- R9: When `sirq_en` is 0, all sixteen outputs are 0, and routing resumes as soon as it returns to 1.
- R10: A slot carries the level of its source, not an edge. It stays at 1 as long as the source is held high and returns to 0 when the source falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration offset for both reads and writes |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Routing byte at `cfg_addr`, or FFh outside the slot range |
| sirq_en | input | 1 | Global serial-IRQ enable |
| src_first | input | 64 | First interrupt line of each device, indexed by device number |
| src_second | input | 64 | Second interrupt line of each device, indexed by device number |
| irq_out | output | 16 | Routed level per IRQ slot |

## Verification
The assertions assume that `cfg_addr`, `cfg_wdata`, the source vectors and the enable are steady around each rising edge. They also assume that no two slots are meant to name the same device; the hardware does not enforce that rule. The bench respects both assumptions. It changes every input only at the falling edge and programs each device into at most one slot at a time. It also clears earlier slots before it reuses a source, so each expected output follows from a single routing byte.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
    localparam int FRAME_W = 6;
    localparam int NUM_LDN = 1 << FRAME_W;
    localparam logic [7:0] ROUTE_OFF = 8'hFF;

    typedef struct packed {
        logic               sel;    // 0: first line, 1: second line
        logic               dev;    // must be 0 for an active slot
        logic [FRAME_W-1:0] frame;  // source device number
    } route_cfg_t;
endpackage

// File: rtl/sirq_route_regs.sv
module sirq_route_regs
    import sirq_pkg::*;
#(
    parameter int                NUM_SLOTS = 16,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] REG_BASE  = 8'h40
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [7:0]                  wdata,
    output logic [7:0]                  rdata,
    output logic [NUM_SLOTS-1:0][7:0]   route
);
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    typedef struct packed {
        logic [NUM_SLOTS-1:0][7:0] route;
    } state_t;

    state_t            st_d, st_q;
    logic              hit;
    logic [SLOT_W-1:0] idx;

    always_comb begin
        hit = (addr >= REG_BASE) &&
              ({1'b0, addr} < ({1'b0, REG_BASE} + (ADDR_W+1)'(NUM_SLOTS)));
        idx = SLOT_W'(addr - REG_BASE);
        st_d = st_q;
        if (wr_en && hit) begin
            st_d.route[idx] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.route <= {NUM_SLOTS{ROUTE_OFF}};
        end else begin
            st_q <= st_d;
        end
    end

    assign route = st_q.route;
    assign rdata = hit ? st_q.route[idx] : ROUTE_OFF;

    // Out-of-range reads see the disabled code
    p_unmapped_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> rdata == ROUTE_OFF);

    for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_chk
        p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == REG_BASE + ADDR_W'(n)) |=> route[n] == $past(wdata));
        p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && addr == REG_BASE + ADDR_W'(n)) |=> $stable(route[n]));
    end
endmodule

// File: rtl/sirq_slot_mux.sv
module sirq_slot_mux
    import sirq_pkg::*;
#(
    parameter logic [NUM_LDN-1:0] HAS_FIRST  = 64'h0000_0000_0000_1E9B,
    parameter logic [NUM_LDN-1:0] HAS_SECOND = 64'h0000_0000_0000_0203
) (
    input  logic [7:0]         route_i,
    input  logic               en_i,
    input  logic [NUM_LDN-1:0] src_first_i,
    input  logic [NUM_LDN-1:0] src_second_i,
    output logic               irq_o
);
    route_cfg_t cfg;
    logic       active;
    logic       level;

    always_comb begin
        cfg    = route_cfg_t'(route_i);
        active = en_i && (route_i != ROUTE_OFF) && !cfg.dev;
        if (cfg.sel) begin
            level = src_second_i[cfg.frame] & HAS_SECOND[cfg.frame];
        end else begin
            level = src_first_i[cfg.frame] & HAS_FIRST[cfg.frame];
        end
        irq_o = active & level;
    end
endmodule

// File: rtl/sirq_router.sv
module sirq_router
    import sirq_pkg::*;
#(
    parameter int                 NUM_SLOTS  = 16,
    parameter int                 ADDR_W     = 8,
    parameter logic [ADDR_W-1:0]  REG_BASE   = 8'h40,
    parameter logic [NUM_LDN-1:0] HAS_FIRST  = 64'h0000_0000_0000_1E9B,
    parameter logic [NUM_LDN-1:0] HAS_SECOND = 64'h0000_0000_0000_0203
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr_en,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [7:0]           cfg_wdata,
    output logic [7:0]           cfg_rdata,
    input  logic                 sirq_en,
    input  logic [NUM_LDN-1:0]   src_first,
    input  logic [NUM_LDN-1:0]   src_second,
    output logic [NUM_SLOTS-1:0] irq_out
);
    logic [NUM_SLOTS-1:0][7:0] route;

    sirq_route_regs #(
        .NUM_SLOTS (NUM_SLOTS),
        .ADDR_W    (ADDR_W),
        .REG_BASE  (REG_BASE)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr_en),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .route (route)
    );

    for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
        sirq_slot_mux #(
            .HAS_FIRST  (HAS_FIRST),
            .HAS_SECOND (HAS_SECOND)
        ) u_mux (
            .route_i      (route[n]),
            .en_i         (sirq_en),
            .src_first_i  (src_first),
            .src_second_i (src_second),
            .irq_o        (irq_out[n])
        );

        p_dev_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
            route[n][6] |-> !irq_out[n]);
        p_off_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (route[n] == ROUTE_OFF) |-> !irq_out[n]);
        p_missing_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ((route[n][7] && !HAS_SECOND[route[n][5:0]]) ||
             (!route[n][7] && !HAS_FIRST[route[n][5:0]])) |-> !irq_out[n]);
        p_no_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (!src_first[route[n][5:0]] && !src_second[route[n][5:0]]) |-> !irq_out[n]);
    end

    p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sirq_en |-> irq_out == '0);
endmodule

// File: tb/sirq_router_tb.sv
module sirq_router_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        sirq_en = 1'b1;
    logic [63:0] src_first = '0;
    logic [63:0] src_second = '0;
    logic [15:0] irq_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sirq_router u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .sirq_en    (sirq_en),
        .src_first  (src_first),
        .src_second (src_second),
        .irq_out    (irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Inputs change at the falling edge; register updates at the next rising edge.
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1;
        chk(req, {24'b0, cfg_rdata}, {24'b0, exp});
    endtask

    task automatic clear_all();
        for (int i = 0; i < 16; i++) wr(8'h40 + 8'(i), 8'hFF);
        @(negedge clk);
        src_first = '0; src_second = '0; sirq_en = 1'b1;
    endtask

    task automatic t_reset();
        for (int i = 0; i < 16; i++) rd_chk("R1 reset byte", 8'h40 + 8'(i), 8'hFF);
        chk("R1 reset outputs", {16'b0, irq_out}, 32'h0);
    endtask

    task automatic t_write_read();
        wr(8'h40, 8'h01);
        wr(8'h4F, 8'h83);
        wr(8'h47, 8'h5A);
        rd_chk("R2 readback 40h", 8'h40, 8'h01);
        rd_chk("R2 readback 4Fh", 8'h4F, 8'h83);
        rd_chk("R2 readback 47h", 8'h47, 8'h5A);
        clear_all();
    endtask

    task automatic t_out_of_range();
        wr(8'h41, 8'h01);
        @(negedge clk); src_first[1] = 1'b1;
        wr(8'h3F, 8'h00);
        wr(8'h50, 8'h00);
        wr(8'h07, 8'h00);
        #1;
        chk("R3 output after stray writes", {16'b0, irq_out}, 32'h0002);
        rd_chk("R3 slot kept", 8'h41, 8'h01);
        rd_chk("R3 read 3Fh", 8'h3F, 8'hFF);
        rd_chk("R3 read 50h", 8'h50, 8'hFF);
        clear_all();
    endtask

    task automatic t_first();
        wr(8'h41, 8'h01);  // IRQ1 <- keyboard first line
        wr(8'h44, 8'h03);  // IRQ4 <- device 3
        wr(8'h4A, 8'h0C);  // IRQ10 <- device 0Ch
        @(negedge clk); src_first[1] = 1'b1; #1;
        chk("R4 same-cycle keyboard", {16'b0, irq_out}, 32'h0002);
        src_first[3] = 1'b1; src_first[12] = 1'b1; #1;
        chk("R4 three sources", {16'b0, irq_out}, 32'h0412);
        src_second[1] = 1'b1; src_first[1] = 1'b0; #1;
        chk("R4 second line not used", {16'b0, irq_out}, 32'h0410);
        clear_all();
    endtask

    task automatic t_second();
        wr(8'h4C, 8'h81);  // IRQ12 <- keyboard second (mouse)
        wr(8'h45, 8'h89);  // IRQ5 <- mailbox second
        wr(8'h46, 8'h80);  // IRQ6 <- device 0 second
        @(negedge clk); src_second[1] = 1'b1; #1;
        chk("R5 mouse on IRQ12", {16'b0, irq_out}, 32'h1000);
        src_first[1] = 1'b1; src_first[9] = 1'b1; src_first[0] = 1'b1; #1;
        chk("R5 first lines ignored", {16'b0, irq_out}, 32'h1000);
        src_second[9] = 1'b1; src_second[0] = 1'b1; #1;
        chk("R5 all second lines", {16'b0, irq_out}, 32'h1060);
        clear_all();
    endtask

    task automatic t_device_bit();
        wr(8'h42, 8'h41);
        wr(8'h43, 8'hC1);
        @(negedge clk); src_first = '1; src_second = '1; #1;
        chk("R6 device bit set", {16'b0, irq_out}, 32'h0);
        clear_all();
    endtask

    task automatic t_off_code();
        wr(8'h48, 8'h07);
        wr(8'h48, 8'hFF);
        @(negedge clk); src_first = '1; src_second = '1; #1;
        chk("R7 FFh disables", {16'b0, irq_out}, 32'h0);
        clear_all();
    endtask

    task automatic t_missing();
        wr(8'h49, 8'h02);  // no such device
        wr(8'h4B, 8'h83);  // device 3 has no second line
        wr(8'h4D, 8'h87);  // device 7 has no second line
        @(negedge clk); src_first = '1; src_second = '1; #1;
        chk("R8 missing lines", {16'b0, irq_out}, 32'h0);
        clear_all();
    endtask

    task automatic t_gate();
        wr(8'h40, 8'h0A);
        wr(8'h4E, 8'h0B);
        @(negedge clk); src_first[10] = 1'b1; src_first[11] = 1'b1; sirq_en = 1'b0; #1;
        chk("R9 gated off", {16'b0, irq_out}, 32'h0);
        @(negedge clk); sirq_en = 1'b1; #1;
        chk("R9 gate reopened", {16'b0, irq_out}, 32'h4001);
        clear_all();
    endtask

    task automatic t_level();
        wr(8'h45, 8'h07);
        @(negedge clk); src_first[7] = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            chk("R10 held level", {16'b0, irq_out}, 32'h0020);
        end
        src_first[7] = 1'b0; #1;
        chk("R10 falls with source", {16'b0, irq_out}, 32'h0);
        clear_all();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_read();
        t_out_of_range();
        t_first();
        t_second();
        t_device_bit();
        t_off_code();
        t_missing();
        t_gate();
        t_level();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule